// File: doc/BRIEF.md
# Fast Inter-Processor Interrupt Unit

This per-core unit sends and receives lightweight inter-processor interrupts without going through the system interrupt controller. Software writes a request into one of two request registers. The local register names a core inside the same cluster. The global register also names a destination cluster. Requests leave the unit through a one-entry outgoing slot, which a fabric drains with a ready signal.

Each request carries a two-bit delivery kind. An immediate request is sent at once. A no-wake request is sent with a flag telling the receiver to raise its pending bit without waking the core. A deferred request is parked in a single slot and sent once a shared countdown, counted in reference-clock ticks, has run out. A retract request cancels a parked deferred request to the same destination.

On the receive side, an arriving interrupt sets a pending bit that drives the fast-interrupt output. Arrivals without the no-wake flag also drive the wake output. Software clears both by writing 1 to bit 0 of the status register.

Top module: `fipi_top`

## Requirements
- R1: After reset, txValid, fiqOut and wakeOut are 0 and no deferred request is parked.
- R2: A write to the local request register (wrSel=0) with kind bits [29:28]=0 presents, after the next clock edge, txValid=1, txCore=wrData[3:0], txGlobal=0, txCluster=0 and txNoWake=0.
- R3: A write to the global request register (wrSel=1) also presents txGlobal=1 and txCluster=wrData[20:16].
- R4: While txValid=1 and txReady=0, txValid and all tx fields hold their values. An immediate or no-wake write in such a cycle is dropped. An edge with txValid=1 and txReady=1 empties the slot unless a new request loads it in the same cycle.
- R5: Kind 3 (no-wake) is sent like an immediate request, but with txNoWake=1.
- R6: Kind 2 (deferred) parks the destination and loads the countdown from the control register (wrSel=2, bits [15:0]). Each later edge with refTick=1 decrements a nonzero countdown. At the first edge where the countdown is zero and the slot is free, the request moves to the slot, with txNoWake=0.
- R7: Kind 1 (retract) cancels a parked deferred request only when its scope, core and, for global requests, cluster match. A retract never produces an outgoing request, and a non-matching retract has no effect.
- R8: An expired deferred request waits while the slot is occupied. It also yields to an immediate or no-wake write in the same cycle.
- R9: An edge with rxValid=1 sets fiqOut. It also sets wakeOut unless rxNoWake=1. wakeOut is never 1 while fiqOut is 0.
- R10: A status write (wrSel=3) with bit 0 set clears fiqOut and wakeOut. With bit 0 clear, the write has no effect.
- R11: When an arrival and a status clear share a cycle, fiqOut stays 1. wakeOut then follows only the new arrival's rxNoWake.
- R12: A deferred write while another request is parked replaces the destination and restarts the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 local request, 1 global request, 2 countdown, 3 status |
| wrData | input | 32 | Register write data |
| refTick | input | 1 | One-cycle reference clock tick enable |
| txValid | output | 1 | Outgoing request present |
| txReady | input | 1 | Fabric accepts the outgoing request |
| txGlobal | output | 1 | Outgoing request addresses another cluster |
| txCluster | output | 5 | Destination cluster (0 for local) |
| txCore | output | 4 | Destination core |
| txNoWake | output | 1 | Receiver must not be woken |
| rxValid | input | 1 | Interrupt arriving for this core |
| rxNoWake | input | 1 | Arriving interrupt is no-wake |
| fiqOut | output | 1 | Pending interrupt, fast-interrupt level |
| wakeOut | output | 1 | Wake request to the core |

## Verification
A corrupted parked destination or countdown shows at the ports as a wrong txCore or txCluster, or as a txValid edge that comes early, late or never. That error appears at the edge after the countdown should have expired. A wrong pending or wake flag shows on fiqOut or wakeOut one edge after the arrival or clear that exposes it. Every output is compared against an independent cycle model on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/fipi_pkg.sv
package fipi_pkg;

  // bit positions inside a request or control write
  localparam int REG_W       = 32;
  localparam int CORE_LSB    = 0;
  localparam int CLUSTER_LSB = 16;
  localparam int KIND_LSB    = 28;
  localparam int COUNT_LSB   = 0;
  localparam int CLEAR_BIT   = 0;

  typedef enum logic [1:0] {
    SEL_LOCAL  = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } ipiSelE;

  typedef enum logic [1:0] {
    KIND_NOW     = 2'd0,
    KIND_RETRACT = 2'd1,
    KIND_DEFER   = 2'd2,
    KIND_QUIET   = 2'd3
  } ipiKindE;

  typedef struct packed {
    logic txFromWr;     // load outgoing slot from the write bus
    logic txFromDefer;  // load outgoing slot from the parked request
    logic deferLoad;    // park a new deferred request, restart count
    logic deferDec;     // decrement the countdown
    logic reloadLoad;   // capture a new countdown value
  } ipiStrobeT;

endpackage

// File: rtl/fipi_datapath.sv
module fipi_datapath
  import fipi_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int CLU_W  = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipiStrobeT         stb,
  input  logic              wrGlobal,
  input  logic [CORE_W-1:0] wrCore,
  input  logic [CLU_W-1:0]  wrCluster,
  input  logic              wrQuiet,
  input  logic [CNT_W-1:0]  wrCount,
  output logic              txGlobal,
  output logic [CLU_W-1:0]  txCluster,
  output logic [CORE_W-1:0] txCore,
  output logic              txNoWake,
  output logic              cntZero,
  output logic              retractHit
);

  logic [CNT_W-1:0]  reloadQ, cntQ;
  logic              dGlobal;
  logic [CLU_W-1:0]  dCluster;
  logic [CORE_W-1:0] dCore;
  logic [CLU_W-1:0]  wrClusterEff;

  assign wrClusterEff = wrGlobal ? wrCluster : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ  <= '0;
      cntQ     <= '0;
      dGlobal  <= 1'b0;
      dCluster <= '0;
      dCore    <= '0;
    end else begin
      if (stb.reloadLoad) reloadQ <= wrCount;
      if (stb.deferLoad) begin
        cntQ     <= reloadQ;
        dGlobal  <= wrGlobal;
        dCluster <= wrClusterEff;
        dCore    <= wrCore;
      end else if (stb.deferDec) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txGlobal  <= 1'b0;
      txCluster <= '0;
      txCore    <= '0;
      txNoWake  <= 1'b0;
    end else if (stb.txFromWr) begin
      txGlobal  <= wrGlobal;
      txCluster <= wrClusterEff;
      txCore    <= wrCore;
      txNoWake  <= wrQuiet;
    end else if (stb.txFromDefer) begin
      txGlobal  <= dGlobal;
      txCluster <= dCluster;
      txCore    <= dCore;
      txNoWake  <= 1'b0;
    end
  end

  assign cntZero    = (cntQ == '0);
  assign retractHit = (wrGlobal == dGlobal) && (wrCore == dCore) &&
                      (wrClusterEff == dCluster);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.deferDec |=> cntQ == $past(cntQ) - 1'b1) else $error("count step"); // R6
  AST_DEFER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    stb.deferLoad |=> cntQ == $past(reloadQ)) else $error("count restart"); // R12

endmodule

// File: rtl/fipi_control.sv
module fipi_control
  import fipi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  ipiSelE    wrSel,
  input  ipiKindE   wrKind,
  input  logic      clrBit,
  input  logic      refTick,
  input  logic      txReady,
  input  logic      rxValid,
  input  logic      rxNoWake,
  input  logic      cntZero,
  input  logic      retractHit,
  output ipiStrobeT stb,
  output logic      txValid,
  output logic      fiqOut,
  output logic      wakeOut
);

  logic txFull, armed, pending, wake;
  logic reqWr, immWr, slotFree, cancel, clr;

  assign reqWr    = wrEn && (wrSel == SEL_LOCAL || wrSel == SEL_GLOBAL);
  assign immWr    = reqWr && (wrKind == KIND_NOW || wrKind == KIND_QUIET);
  assign slotFree = !txFull || txReady;
  assign cancel   = reqWr && wrKind == KIND_RETRACT && armed && retractHit;
  assign clr      = wrEn && wrSel == SEL_STATUS && clrBit;

  always_comb begin
    stb.txFromWr    = immWr && slotFree;
    stb.txFromDefer = armed && cntZero && slotFree && !immWr;
    stb.deferLoad   = reqWr && wrKind == KIND_DEFER;
    stb.deferDec    = armed && refTick && !cntZero && !stb.deferLoad;
    stb.reloadLoad  = wrEn && wrSel == SEL_COUNT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFull  <= 1'b0;
      armed   <= 1'b0;
      pending <= 1'b0;
      wake    <= 1'b0;
    end else begin
      if (stb.txFromWr || stb.txFromDefer) txFull <= 1'b1;
      else if (txReady)                     txFull <= 1'b0;
      if (stb.deferLoad)                   armed <= 1'b1;
      else if (cancel || stb.txFromDefer)  armed <= 1'b0;
      pending <= rxValid || (pending && !clr);
      wake    <= (rxValid && !rxNoWake) || (wake && !clr);
    end
  end

  assign txValid = txFull;
  assign fiqOut  = pending;
  assign wakeOut = wake;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid) else $error("tx dropped"); // R4
  AST_WAKE_NEEDS_FIQ: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> fiqOut) else $error("wake without fiq"); // R9
  AST_ARRIVAL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> fiqOut) else $error("arrival lost"); // R11
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr && !rxValid |=> !fiqOut && !wakeOut) else $error("clear failed"); // R10
  AST_QUIET_RX: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxNoWake && !wakeOut |=> !wakeOut) else $error("quiet woke"); // R9

endmodule

// File: rtl/fipi_top.sv
module fipi_top
  import fipi_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int CLU_W  = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              refTick,
  output logic              txValid,
  input  logic              txReady,
  output logic              txGlobal,
  output logic [CLU_W-1:0]  txCluster,
  output logic [CORE_W-1:0] txCore,
  output logic              txNoWake,
  input  logic              rxValid,
  input  logic              rxNoWake,
  output logic              fiqOut,
  output logic              wakeOut
);

  ipiStrobeT stb;
  ipiSelE    sel;
  ipiKindE   kind;
  logic      cntZero, retractHit;
  logic      unusedWr;

  assign sel      = ipiSelE'(wrSel);
  assign kind     = ipiKindE'(wrData[KIND_LSB +: 2]);
  assign unusedWr = ^wrData;

  fipi_control uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(sel), .wrKind(kind),
    .clrBit(wrData[CLEAR_BIT]), .refTick(refTick), .txReady(txReady),
    .rxValid(rxValid), .rxNoWake(rxNoWake), .cntZero(cntZero),
    .retractHit(retractHit), .stb(stb), .txValid(txValid),
    .fiqOut(fiqOut), .wakeOut(wakeOut)
  );

  fipi_datapath #(.CORE_W(CORE_W), .CLU_W(CLU_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrGlobal(sel == SEL_GLOBAL),
    .wrCore(wrData[CORE_LSB +: CORE_W]),
    .wrCluster(wrData[CLUSTER_LSB +: CLU_W]),
    .wrQuiet(kind == KIND_QUIET),
    .wrCount(wrData[COUNT_LSB +: CNT_W]),
    .txGlobal(txGlobal), .txCluster(txCluster), .txCore(txCore),
    .txNoWake(txNoWake), .cntZero(cntZero), .retractHit(retractHit)
  );

  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable({txGlobal, txCluster, txCore, txNoWake}))
    else $error("tx fields moved"); // R4
  AST_LOCAL_CLUSTER: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txGlobal |-> txCluster == '0) else $error("local cluster"); // R2

endmodule

// File: tb/tb_fipi_top.sv
module tb_fipi_top;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, refTick = 0, txReady = 0, rxValid = 0, rxNoWake = 0;
  logic [1:0] wrSel = 0;
  logic [31:0] wrData = 0;
  logic txValid, txGlobal, txNoWake, fiqOut, wakeOut;
  logic [4:0] txCluster;
  logic [3:0] txCore;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  fipi_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .refTick(refTick), .txValid(txValid), .txReady(txReady),
    .txGlobal(txGlobal), .txCluster(txCluster), .txCore(txCore),
    .txNoWake(txNoWake), .rxValid(rxValid), .rxNoWake(rxNoWake),
    .fiqOut(fiqOut), .wakeOut(wakeOut)
  );

  // independent cycle model built from the requirements
  logic mTxV, mTxG, mTxNw, mArm, mDG, mPend, mWake;
  logic [4:0] mTxCl, mDCl;
  logic [3:0] mTxCo, mDCo;
  logic [15:0] mCnt, mReload;

  always @(posedge clk) begin
    logic isReq, g, immW, fire, freeS, clrS, hit;
    logic [1:0] k;
    logic [4:0] cl;
    if (!rstN) begin
      mTxV = 0; mTxG = 0; mTxNw = 0; mArm = 0; mDG = 0; mPend = 0; mWake = 0;
      mTxCl = 0; mDCl = 0; mTxCo = 0; mDCo = 0; mCnt = 0; mReload = 0;
    end else begin
      isReq = wrEn && wrSel < 2;
      g     = wrSel == 1;
      k     = wrData[29:28];
      cl    = g ? wrData[20:16] : 5'd0;
      immW  = isReq && (k == 0 || k == 3);
      freeS = !mTxV || txReady;
      fire  = mArm && mCnt == 0 && freeS && !immW;
      hit   = g == mDG && wrData[3:0] == mDCo && cl == mDCl;
      clrS  = wrEn && wrSel == 3 && wrData[0];
      if (immW && freeS) begin
        mTxV = 1; mTxG = g; mTxCl = cl; mTxCo = wrData[3:0]; mTxNw = (k == 3);
      end else if (fire) begin
        mTxV = 1; mTxG = mDG; mTxCl = mDCl; mTxCo = mDCo; mTxNw = 0;
      end else if (txReady) mTxV = 0;
      if (isReq && k == 2) begin
        mArm = 1; mCnt = mReload; mDG = g; mDCl = cl; mDCo = wrData[3:0];
      end else if ((isReq && k == 1 && mArm && hit) || fire) mArm = 0;
      else if (mArm && refTick && mCnt != 0) mCnt = mCnt - 1;
      if (wrEn && wrSel == 2) mReload = wrData[15:0];
      mWake = (rxValid && !rxNoWake) || (mWake && !clrS);
      mPend = rxValid || (mPend && !clrS);
    end
  end

  task automatic expect1(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    expect1(tag, "txValid", txValid, mTxV);
    if (mTxV) begin
      expect1(tag, "txGlobal", txGlobal, mTxG);
      expect1(tag, "txCluster", txCluster, mTxCl);
      expect1(tag, "txCore", txCore, mTxCo);
      expect1(tag, "txNoWake", txNoWake, mTxNw);
    end
    expect1(tag, "fiqOut", fiqOut, mPend);
    expect1(tag, "wakeOut", wakeOut, mWake);
  endtask

  task automatic step(string tag);
    @(posedge clk); @(negedge clk);
    checkAll(tag);
    wrEn = 0; rxValid = 0; rxNoWake = 0; refTick = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d, string tag);
    wrEn = 1; wrSel = s; wrData = d;
    step(tag);
  endtask

  function automatic logic [31:0] req(logic [1:0] k, logic [4:0] c, logic [3:0] core);
    return {2'b0, k, 7'b0, c, 12'b0, core};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1");
    expect1("R1", "txValid", txValid, 0);
    expect1("R1", "fiqOut", fiqOut, 0);
    // R2 local immediate
    wr(0, req(0, 5'h1f, 4'd5), "R2");
    expect1("R2", "txCore", txCore, 5);
    expect1("R2", "txCluster", txCluster, 0);
    // R4 hold and drop
    step("R4"); step("R4");
    wr(0, req(0, 0, 4'd9), "R4");
    expect1("R4", "txCore", txCore, 5);
    txReady = 1; step("R4");
    expect1("R4", "txValid", txValid, 0);
    // R3 global
    txReady = 0;
    wr(1, req(0, 5'h15, 4'd3), "R3");
    expect1("R3", "txCluster", txCluster, 5'h15);
    expect1("R3", "txGlobal", txGlobal, 1);
    txReady = 1; step("R3");
    // R5 no-wake
    wr(0, req(3, 0, 4'd2), "R5");
    expect1("R5", "txNoWake", txNoWake, 1);
    step("R5");
    // R6 deferred with three ticks
    wr(2, 32'd3, "R6");
    wr(0, req(2, 0, 4'd7), "R6");
    for (int i = 0; i < 3; i++) begin
      step("R6");
      refTick = 1; step("R6");
    end
    expect1("R6", "txValid", txValid, 0);
    step("R6");
    expect1("R6", "txValid", txValid, 1);
    expect1("R6", "txCore", txCore, 7);
    step("R6");
    // R7 retract
    wr(2, 32'd10, "R7");
    wr(1, req(2, 5'd2, 4'd4), "R7");
    wr(1, req(1, 5'd3, 4'd4), "R7");
    wr(0, req(1, 5'd2, 4'd4), "R7");
    wr(1, req(1, 5'd2, 4'd4), "R7");
    for (int i = 0; i < 14; i++) begin
      refTick = 1; step("R7");
    end
    expect1("R7", "txValid", txValid, 0);
    // R8 expiry waits for occupied slot
    txReady = 0;
    wr(2, 32'd0, "R8");
    wr(0, req(0, 0, 4'd1), "R8");
    wr(0, req(2, 0, 4'd6), "R8");
    step("R8"); step("R8");
    expect1("R8", "txCore", txCore, 1);
    txReady = 1; step("R8");
    expect1("R8", "txCore", txCore, 6);
    step("R8");
    // R12 re-arm
    wr(2, 32'd5, "R12");
    wr(0, req(2, 0, 4'd3), "R12");
    refTick = 1; step("R12");
    refTick = 1; step("R12");
    wr(1, req(2, 5'd9, 4'd8), "R12");
    for (int i = 0; i < 8; i++) begin
      refTick = 1; step("R12");
    end
    // R9 / R10 / R11
    rxValid = 1; step("R9");
    expect1("R9", "wakeOut", wakeOut, 1);
    wr(3, 32'd0, "R10");
    expect1("R10", "fiqOut", fiqOut, 1);
    wr(3, 32'd1, "R10");
    expect1("R10", "fiqOut", fiqOut, 0);
    rxValid = 1; rxNoWake = 1; step("R9");
    expect1("R9", "wakeOut", wakeOut, 0);
    rxValid = 1; wrEn = 1; wrSel = 3; wrData = 1; step("R11");
    expect1("R11", "fiqOut", fiqOut, 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5) begin
        wrEn = 1;
        wrSel = 2'($urandom_range(0, 3));
        wrData = req(2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                     4'($urandom_range(0, 3)));
        if (wrSel == 2) wrData = 32'($urandom_range(0, 4));
        if (wrSel == 3) wrData = 32'($urandom_range(0, 1));
      end
      rxValid  = ($urandom_range(0, 5) == 0);
      rxNoWake = $urandom_range(0, 1) == 1;
      refTick  = $urandom_range(0, 1) == 1;
      txReady  = $urandom_range(0, 2) != 0;
      step("R4");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule